// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

The block is one direction of a two-way buffer between two independently clocked agents. A producer writes 18-bit words on its own clock. A consumer reads them on an unrelated clock, in the order they were written, through a registered output. The store holds 512 words.

Four active-low status flags report the fill level. Full and almost-full live in the write clock domain. Empty and almost-empty live in the read clock domain. The almost-full and almost-empty thresholds sit in offset registers that the producer side can reload at run time. Both offsets return to 8 on reset. A bidirectional link is built from two instances, one per direction.

Each side keeps its own pointer, one bit wider than the address, with the extra bit used for wrap detection. Each pointer crosses to the other domain in Gray code through a two-flop synchronizer. Because the far pointer arrives late, every flag is pessimistic: a flag may stay asserted for a few cycles after the real level has left its region, but it never reports room or data that is not there.

Top module: `xpf_fifo`

## Requirements
- R1: Words leave `rd_data` in the exact order they were accepted, without loss or duplication, and up to 512 words can be held at once.
- R2: A write happens on a rising `wclk` edge only when `wr_en` is 1 and `full_n` is 1. A write attempted while `full_n` is 0 is ignored: no word is stored and the write pointer stays unchanged.
- R3: When `rd_en` is 1 and `empty_n` is 1 at a rising `rclk` edge, the next word appears on `rd_data` after that edge. A read attempted while `empty_n` is 0 leaves `rd_data` and the read pointer unchanged.
- R4: While `rst_n` is 0, both pointers clear to the first location and both offsets become 8. Reset forces `empty_n`=0, `aempty_n`=0, `full_n`=1 and `afull_n`=1.
- R5: `full_n` is 0 exactly when the write side's view of the word count equals 512. It is never 1 while 512 words are stored.
- R6: `empty_n` is 0 exactly when the read side's view of the word count is 0. It is never 1 while no word is stored.
- R7: `aempty_n` is 0 when the read side's word count is less than or equal to the almost-empty offset. As a result, `empty_n`=0 always implies `aempty_n`=0.
- R8: `afull_n` is 0 when the free space seen by the write side (512 minus the count) is less than or equal to the almost-full offset. As a result, `full_n`=0 always implies `afull_n`=0.
- R9: When `ofs_ld` is 1 at a rising `wclk` edge, `ofs_val` is loaded into the offset selected by `ofs_sel`, where 0 selects almost-empty and 1 selects almost-full. The almost-empty offset reaches the read domain after two `rclk` edges. Offsets are meant to be changed only while the level is steady.
- R10: Each pointer crosses domains in Gray code, so the crossing bus changes in at most one bit per source clock. Once both clocks have run a few cycles with no traffic, all four flags match the stored count exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wclk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Word to store |
| full_n | output | 1 | Low when no room is left |
| afull_n | output | 1 | Low when free space is at or below the almost-full offset |
| ofs_ld | input | 1 | Load strobe for an offset register (write clock) |
| ofs_sel | input | 1 | Offset select: 0 almost-empty, 1 almost-full |
| ofs_val | input | 9 | New offset value |
| rclk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read request |
| rd_data | output | 18 | Registered output word |
| empty_n | output | 1 | Low when no word is available |
| aempty_n | output | 1 | Low when the count is at or below the almost-empty offset |

## Verification
The bound assertions check several properties on every cycle of their own clock: a write refused while full leaves the write pointer still, a read refused while empty leaves the read pointer and output still, an accepted write advances the pointer by exactly one, and each Gray crossing bus moves by at most one bit. They also check that an asserted full or empty flag always carries its almost- flag with it, and that reset forces the defined flag levels. Three things can only be shown by the bench's scenarios against its queue model: end-to-end word order across unrelated clocks, the exact threshold at which each programmable flag switches under the default and reloaded offsets, and the restoration of the offsets by a second reset.

// File: rtl/xpf_pkg.sv
package xpf_pkg;

    localparam int unsigned XPF_DW      = 18;
    localparam int unsigned XPF_AW      = 9;
    localparam int unsigned XPF_OFS_RST = 8;

    typedef enum logic {
        OFS_AEMPTY = 1'b0,
        OFS_AFULL  = 1'b1
    } ofs_sel_e;

    typedef struct packed {
        logic full_n;
        logic afull_n;
    } wflags_t;

    typedef struct packed {
        logic empty_n;
        logic aempty_n;
    } rflags_t;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xpf_sync.sv
module xpf_sync #(
    parameter int unsigned   W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/xpf_wr_side.sv
module xpf_wr_side
    import xpf_pkg::*;
#(
    parameter int unsigned AW = XPF_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_s,
    input  logic [AW-1:0] af_ofs,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          wr_ok,
    output wflags_t       flags
);
    localparam int unsigned PW    = AW + 1;
    localparam logic [AW:0] DEPTH = PW'(1) << AW;

    logic [AW:0] rbin_view;
    logic [AW:0] level;
    logic [AW:0] room;
    logic [AW:0] wbin_nx;

    assign rbin_view = PW'(gray_to_bin(32'(rgray_s)));
    assign level     = wbin - rbin_view;
    assign room      = DEPTH - level;

    assign flags.full_n  = (level != DEPTH);
    assign flags.afull_n = !(room <= {1'b0, af_ofs});

    assign wr_ok   = wr_en && flags.full_n;
    assign wbin_nx = wbin + PW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_ok) begin
            wbin  <= wbin_nx;
            wgray <= PW'(bin_to_gray(32'(wbin_nx)));
        end
    end
endmodule

// File: rtl/xpf_rd_side.sv
module xpf_rd_side
    import xpf_pkg::*;
#(
    parameter int unsigned AW = XPF_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] ae_ofs,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic          rd_ok,
    output rflags_t       flags
);
    localparam int unsigned PW = AW + 1;

    logic [AW:0] wbin_view;
    logic [AW:0] level;
    logic [AW:0] rbin_nx;

    assign wbin_view = PW'(gray_to_bin(32'(wgray_s)));
    assign level     = wbin_view - rbin;

    assign flags.empty_n  = (level != '0);
    assign flags.aempty_n = !(level <= {1'b0, ae_ofs});

    assign rd_ok   = rd_en && flags.empty_n;
    assign rbin_nx = rbin + PW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_ok) begin
            rbin  <= rbin_nx;
            rgray <= PW'(bin_to_gray(32'(rbin_nx)));
        end
    end
endmodule

// File: rtl/xpf_store.sv
module xpf_store
    import xpf_pkg::*;
#(
    parameter int unsigned DW = XPF_DW,
    parameter int unsigned AW = XPF_AW
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned WORDS = 1 << AW;

    logic [DW-1:0] cells [WORDS];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/xpf_fifo.sv
module xpf_fifo
    import xpf_pkg::*;
#(
    parameter int unsigned DW      = XPF_DW,
    parameter int unsigned AW      = XPF_AW,
    parameter int unsigned OFS_RST = XPF_OFS_RST
) (
    input  logic          rst_n,
    input  logic          wclk,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full_n,
    output logic          afull_n,
    input  logic          ofs_ld,
    input  logic          ofs_sel,
    input  logic [AW-1:0] ofs_val,
    input  logic          rclk,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty_n,
    output logic          aempty_n
);
    localparam int unsigned PW       = AW + 1;
    localparam logic [AW-1:0] OFS_DEF = AW'(OFS_RST);

    logic [AW:0]   w_bin, w_gray, r_bin, r_gray;
    logic [AW:0]   wg_sync, rg_sync;
    logic [AW-1:0] ae_ofs_w, af_ofs_w, ae_ofs_r;
    logic          wr_ok, rd_ok;
    wflags_t       wfl;
    rflags_t       rfl;

    // offset registers, hosted in the write clock domain
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            ae_ofs_w <= OFS_DEF;
            af_ofs_w <= OFS_DEF;
        end else if (ofs_ld) begin
            case (ofs_sel_e'(ofs_sel))
                OFS_AEMPTY: ae_ofs_w <= ofs_val;
                OFS_AFULL:  af_ofs_w <= ofs_val;
                default:    ;
            endcase
        end
    end

    xpf_sync #(.W(AW), .RST_VAL(OFS_DEF)) u_ae_sync (
        .clk(rclk), .rst_n(rst_n), .d(ae_ofs_w), .q(ae_ofs_r)
    );

    xpf_sync #(.W(PW), .RST_VAL('0)) u_rptr_sync (
        .clk(wclk), .rst_n(rst_n), .d(r_gray), .q(rg_sync)
    );

    xpf_sync #(.W(PW), .RST_VAL('0)) u_wptr_sync (
        .clk(rclk), .rst_n(rst_n), .d(w_gray), .q(wg_sync)
    );

    xpf_wr_side #(.AW(AW)) u_wr (
        .clk(wclk), .rst_n(rst_n), .wr_en(wr_en), .rgray_s(rg_sync),
        .af_ofs(af_ofs_w), .wbin(w_bin), .wgray(w_gray), .wr_ok(wr_ok),
        .flags(wfl)
    );

    xpf_rd_side #(.AW(AW)) u_rd (
        .clk(rclk), .rst_n(rst_n), .rd_en(rd_en), .wgray_s(wg_sync),
        .ae_ofs(ae_ofs_r), .rbin(r_bin), .rgray(r_gray), .rd_ok(rd_ok),
        .flags(rfl)
    );

    xpf_store #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wclk), .we(wr_ok), .waddr(w_bin[AW-1:0]), .wdata(wr_data),
        .rclk(rclk), .rst_n(rst_n), .re(rd_ok), .raddr(r_bin[AW-1:0]),
        .rdata(rd_data)
    );

    assign full_n   = wfl.full_n;
    assign afull_n  = wfl.afull_n;
    assign empty_n  = rfl.empty_n;
    assign aempty_n = rfl.aempty_n;
endmodule

// File: rtl/xpf_fifo_chk.sv
module xpf_fifo_chk #(
    parameter int unsigned DW = 18,
    parameter int unsigned AW = 9
) (
    input logic          rst_n,
    input logic          wclk,
    input logic          rclk,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full_n,
    input logic          afull_n,
    input logic          empty_n,
    input logic          aempty_n,
    input logic [AW:0]   w_bin,
    input logic [AW:0]   r_bin,
    input logic [AW:0]   w_gray,
    input logic [AW:0]   r_gray,
    input logic [DW-1:0] rd_data
);
    a_r2_full_blocks_write: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && !full_n) |=> $stable(w_bin));

    a_r2_write_advances: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && full_n) |=> (w_bin == $past(w_bin) + 1'b1));

    a_r3_empty_blocks_read: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_en && !empty_n) |=> ($stable(r_bin) && $stable(rd_data)));

    a_r8_full_implies_afull: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    a_r7_empty_implies_aempty: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    a_r10_wgray_one_bit: assert property (@(posedge wclk) disable iff (!rst_n)
        $onehot0(w_gray ^ $past(w_gray)));

    a_r10_rgray_one_bit: assert property (@(posedge rclk) disable iff (!rst_n)
        $onehot0(r_gray ^ $past(r_gray)));

    a_r4_reset_wflags: assert property (@(posedge wclk)
        !rst_n |-> (full_n && afull_n));

    a_r4_reset_rflags: assert property (@(posedge rclk)
        !rst_n |-> (!empty_n && !aempty_n));
endmodule

bind xpf_fifo xpf_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
    .rst_n(rst_n), .wclk(wclk), .rclk(rclk), .wr_en(wr_en), .rd_en(rd_en),
    .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
    .w_bin(w_bin), .r_bin(r_bin), .w_gray(w_gray), .r_gray(r_gray),
    .rd_data(rd_data)
);

// File: tb/xpf_fifo_bench.sv
module xpf_fifo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = 14;
    localparam int DEPTH      = 512;

    logic        rst_n = 1'b0;
    logic        wclk = 1'b0, rclk = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [17:0] wr_data = '0;
    logic        ofs_ld = 1'b0, ofs_sel = 1'b0;
    logic [8:0]  ofs_val = '0;
    logic        full_n, afull_n, empty_n, aempty_n;
    logic [17:0] rd_data;

    int checks = 0;
    int errors = 0;
    int ae_exp = 8;
    int af_exp = 8;
    int seed_ctr = 0;
    bit done = 0;
    logic [17:0] q[$];

    always #(CLK_PERIOD/2) wclk = ~wclk;
    always #(RD_PERIOD/2)  rclk = ~rclk;

    xpf_fifo u_xpf_fifo (
        .rst_n(rst_n), .wclk(wclk), .wr_en(wr_en), .wr_data(wr_data),
        .full_n(full_n), .afull_n(afull_n), .ofs_ld(ofs_ld), .ofs_sel(ofs_sel),
        .ofs_val(ofs_val), .rclk(rclk), .rd_en(rd_en), .rd_data(rd_data),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] next_word();
        seed_ctr++;
        return 18'((seed_ctr * 40503) ^ (seed_ctr << 7));
    endfunction

    task automatic wr_word(output bit acc);
        logic [17:0] d;
        d = next_word();
        @(negedge wclk);
        wr_en = 1'b1;
        wr_data = d;
        acc = full_n;
        if (full_n && q.size() >= DEPTH)
            check(0, "R5 full_n high while store holds 512", q.size(), DEPTH - 1);
        @(posedge wclk);
        #1;
        wr_en = 1'b0;
        if (acc) q.push_back(d);
    endtask

    task automatic wr_n(input int n);
        bit a;
        for (int i = 0; i < n; i++) wr_word(a);
    endtask

    task automatic rd_word(output bit acc);
        logic [17:0] prev, exp;
        @(negedge rclk);
        rd_en = 1'b1;
        acc = empty_n;
        prev = rd_data;
        if (empty_n && q.size() == 0)
            check(0, "R6 empty_n high while store is empty", 1, 0);
        @(posedge rclk);
        #1;
        rd_en = 1'b0;
        if (acc && q.size() > 0) begin
            exp = q.pop_front();
            check(rd_data == exp, "R1 R3 read data order", int'(rd_data), int'(exp));
        end else if (!acc) begin
            check(rd_data == prev, "R3 rd_data held on read while empty",
                  int'(rd_data), int'(prev));
        end
    endtask

    task automatic settle();
        repeat (8) @(posedge rclk);
        repeat (8) @(posedge wclk);
    endtask

    task automatic check_flags(input string ctx);
        int c;
        c = q.size();
        settle();
        @(negedge wclk);
        check(full_n == (c != DEPTH), {"R5 full_n ", ctx}, full_n, int'(c != DEPTH));
        check(afull_n == !((DEPTH - c) <= af_exp), {"R8 afull_n ", ctx},
              afull_n, int'(!((DEPTH - c) <= af_exp)));
        @(negedge rclk);
        check(empty_n == (c != 0), {"R6 empty_n ", ctx}, empty_n, int'(c != 0));
        check(aempty_n == !(c <= ae_exp), {"R7 aempty_n ", ctx},
              aempty_n, int'(!(c <= ae_exp)));
    endtask

    task automatic load_ofs(input bit sel, input int val);
        @(negedge wclk);
        ofs_ld = 1'b1;
        ofs_sel = sel;
        ofs_val = 9'(val);
        @(posedge wclk);
        #1;
        ofs_ld = 1'b0;
        if (sel) af_exp = val; else ae_exp = val;
    endtask

    task automatic drain();
        bit a;
        while (q.size() > 0) rd_word(a);
    endtask

    task automatic do_reset();
        @(negedge wclk);
        rst_n = 1'b0;
        repeat (4) @(negedge rclk);
        #1;
        rst_n = 1'b1;
        q.delete();
        ae_exp = 8;
        af_exp = 8;
    endtask

    initial begin
        bit a;
        int n;
        int wr_cnt, rd_cnt;
        // R4: reset state
        repeat (3) @(negedge rclk);
        check(full_n == 1 && afull_n == 1, "R4 write flags during reset",
              int'({full_n, afull_n}), 3);
        check(empty_n == 0 && aempty_n == 0, "R4 read flags during reset",
              int'({empty_n, aempty_n}), 0);
        #1;
        rst_n = 1'b1;
        check_flags("after reset");

        // R4 R7: default almost-empty offset of 8
        wr_n(8);
        check_flags("count 8 default offset");
        wr_n(1);
        check_flags("count 9 default offset");

        // R1 R3: partial read, then drain and read while empty
        for (int i = 0; i < 3; i++) rd_word(a);
        check_flags("count 6");
        drain();
        check_flags("drained");
        rd_word(a);
        check(a == 0, "R3 read refused while empty", a, 0);

        // R2 R5 R8: fill to the top with default almost-full offset
        wr_n(503);
        check_flags("free 9");
        wr_n(1);
        check_flags("free 8");
        wr_n(8);
        check_flags("full");
        n = 0;
        for (int i = 0; i < 5; i++) begin
            wr_word(a);
            if (a) n++;
        end
        check(n == 0, "R2 writes while full accepted", n, 0);
        check(q.size() == DEPTH, "R2 model count after refused writes", q.size(), DEPTH);
        drain();
        check_flags("drained after full");

        // R9: reloaded offsets
        load_ofs(1'b0, 20);
        load_ofs(1'b1, 100);
        settle();
        wr_n(20);
        check_flags("R9 count 20 ae=20");
        wr_n(1);
        check_flags("R9 count 21 ae=20");
        wr_n(390);
        check_flags("R9 count 411 af=100");
        wr_n(1);
        check_flags("R9 count 412 af=100");
        drain();
        check_flags("R9 drained");

        // R4: second reset clears contents and restores offsets
        wr_n(30);
        do_reset();
        check_flags("R4 after second reset");
        wr_n(9);
        check_flags("R4 offset back to 8 at count 9");
        drain();

        // R1 R10: concurrent traffic on both clocks
        wr_cnt = 0;
        rd_cnt = 0;
        fork
            begin
                bit wa;
                while (wr_cnt < 300) begin
                    wr_word(wa);
                    if (wa) wr_cnt++;
                end
            end
            begin
                bit ra;
                int k;
                k = 0;
                while (rd_cnt < 300) begin
                    rd_word(ra);
                    if (ra) rd_cnt++;
                    k++;
                    if (k % 4 == 0) repeat (2) @(posedge rclk);
                end
            end
        join
        check(rd_cnt == wr_cnt, "R1 streamed words all returned", rd_cnt, wr_cnt);
        check_flags("R10 after streaming");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule